// File: doc/BRIEF.md
# LCD Power-Up Command Sequencer

This block brings a monochrome graphic LCD controller out of reset and into a displaying state without any software involvement. It holds an internal step list in which each entry is either a command byte to shift out over a write-only serial link or a control action: set the chip-select line, set the command/data select line, pull the panel reset low for a number of milliseconds, or pause for a number of milliseconds. The list brings up the charge pump, the regulator and the follower in three separate stages, with a settling pause after each stage.

The sequence starts by itself when the synchronous reset is released. It sets `done` once the last step has run. A one-cycle `start` pulse given while `done` is high runs the whole list again from its first step. The serial clock half-period is a parameter. The block raises it, if needed, so that the full period is never shorter than 300 ns at the clock rate given by `CLK_HZ`. The millisecond timebase is derived from the same parameter.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While `rst` is high, `lcd_cs_n`=1, `lcd_dc`=0, `lcd_rst_n`=1, `lcd_sck`=0, `done`=0 and `busy`=1. On release the sequence starts without a `start` pulse.
- R2: Before the panel reset goes low, chip select is driven high, then command mode (`lcd_dc`=0) is selected, then chip select is driven low. `lcd_cs_n` and `lcd_dc` are both 0 for the whole time `lcd_rst_n` is 0.
- R3: `lcd_rst_n` stays low for 242 ms (242·CLK_HZ/1000 cycles, plus at most 4 cycles). No serial byte is sent before it returns high.
- R4: Exactly eleven bytes are sent per run, all with `lcd_dc`=0, in this order: A3, A0, C8, C2, 40, 2C, 2E, 2F, 26, AF, A6 (hex).
- R5: Bytes go MSB first in SPI mode 0. `lcd_sck` idles low, `lcd_mosi` changes only while `lcd_sck` is low, and the receiver samples on the rising edge. The serial clock period is 2·max(SCK_HALF, ceil(300 ns·CLK_HZ/2)) cycles. `lcd_sck` is 0 whenever `lcd_cs_n` is 1.
- R6: The gap from the end of byte 2C to the start of byte 2E is at least 50 ms. The gap from 2E to 2F is at least 50 ms, and the gap from 2F to 26 is at least 10 ms. Each of these waits exceeds its minimum by at most 40 cycles. Every other pair of consecutive bytes is separated by at most 40 cycles.
- R7: From the last byte (A6), `lcd_cs_n` rises between 100 ms and 100 ms + 40 cycles later. `done` rises 0 to 4 cycles after that.
- R8: A `start` pulse while `busy`=1 has no effect: the run still sends eleven bytes and one reset pulse, and it ends at the normal time.
- R9: A `start` pulse while `done`=1 clears `done` and sets `busy` on the next cycle. The full sequence then runs again from its first step.
- R10: `busy` and `done` are never 1 together. After `done`, the outputs hold `lcd_cs_n`=1 and `lcd_rst_n`=1 and send nothing until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence again once it is done |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Command/data select, 0 = command |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_sck | output | 1 | Serial clock, idle low |
| lcd_mosi | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |

## Verification
A step counter that is off by one shows up on `lcd_mosi` within a single byte time. The next byte is missing, repeated or swapped, or a wait falls between the wrong pair of bytes, which changes a measured gap by tens of milliseconds. A millisecond timebase that counts wrong moves the edges of the reset pulse and of every wait, so it shows in the first 242 ms of every run. A serializer fault shows at the first rising edge of `lcd_sck` as a wrong bit, a wrong period, or `lcd_mosi` changing while the clock is high. A control state that fails to return to idle shows as `done` missing, `done` set together with `busy`, or a re-run that does not start one cycle after `start`.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int MS_W       = 8;
    localparam int VAL_W      = 8;
    localparam int STEP_COUNT = 21;
    localparam int PC_W       = $clog2(STEP_COUNT);

    localparam logic [MS_W-1:0] PANEL_RST_MS = MS_W'(15 * 16 + 2);

    typedef enum logic [2:0] {
        OP_CSN    = 3'd0,
        OP_DCSEL  = 3'd1,
        OP_PANRST = 3'd2,
        OP_PAUSE  = 3'd3,
        OP_SEND   = 3'd4,
        OP_FINISH = 3'd5
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_SPI  = 2'd2,
        ST_TMR  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_op_e          op;
        logic [VAL_W-1:0] val;
    } seq_step_t;

    function automatic seq_step_t mk(input seq_op_e o, input logic [VAL_W-1:0] v);
        seq_step_t s;
        s.op  = o;
        s.val = v;
        return s;
    endfunction

    // Step list; order is behaviour (power stages must ramp in this order).
    function automatic seq_step_t step_at(input logic [PC_W-1:0] idx);
        case (idx)
            5'd0:    return mk(OP_CSN,    8'h01);        // chip select released
            5'd1:    return mk(OP_DCSEL,  8'h00);        // command mode
            5'd2:    return mk(OP_CSN,    8'h00);        // chip select driven
            5'd3:    return mk(OP_PANRST, PANEL_RST_MS);
            5'd4:    return mk(OP_SEND,   8'hA3);
            5'd5:    return mk(OP_SEND,   8'hA0);
            5'd6:    return mk(OP_SEND,   8'hC8);
            5'd7:    return mk(OP_SEND,   8'hC2);
            5'd8:    return mk(OP_SEND,   8'h40);
            5'd9:    return mk(OP_SEND,   8'h2C);        // pump stage
            5'd10:   return mk(OP_PAUSE,  8'd50);
            5'd11:   return mk(OP_SEND,   8'h2E);        // regulator stage
            5'd12:   return mk(OP_PAUSE,  8'd50);
            5'd13:   return mk(OP_SEND,   8'h2F);        // follower stage
            5'd14:   return mk(OP_PAUSE,  8'd10);
            5'd15:   return mk(OP_SEND,   8'h26);
            5'd16:   return mk(OP_SEND,   8'hAF);
            5'd17:   return mk(OP_SEND,   8'hA6);
            5'd18:   return mk(OP_PAUSE,  8'd100);
            5'd19:   return mk(OP_CSN,    8'h01);
            default: return mk(OP_FINISH, 8'h00);
        endcase
    endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer
    import lcd_seq_pkg::*;
#(
    parameter int TICK_CYC = 50_000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            fin
);
    localparam int SUB_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(TICK_CYC - 1);

    logic [MS_W-1:0]  ms_left;
    logic [SUB_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_left <= '0;
            sub     <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                ms_left <= load_ms;
                sub     <= SUB_TOP;
            end else if (ms_left != '0) begin
                if (sub == '0) begin
                    sub     <= SUB_TOP;
                    ms_left <= ms_left - 1'b1;
                    if (ms_left == MS_W'(1)) fin <= 1'b1;
                end else begin
                    sub <= sub - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_spi_byte_tx.sv
module lcd_spi_byte_tx #(
    parameter int HALF = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] din,
    output logic       sck,
    output logic       mosi,
    output logic       fin
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TW-1:0] T_TOP = TW'(HALF - 1);

    logic [7:0]    sh;
    logic [3:0]    hidx;
    logic [TW-1:0] tcnt;
    logic          active;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            hidx   <= '0;
            tcnt   <= '0;
            active <= 1'b0;
            sck    <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                sh     <= din;
                hidx   <= '0;
                tcnt   <= '0;
                active <= 1'b1;
                sck    <= 1'b0;
            end else if (active) begin
                if (tcnt == T_TOP) begin
                    tcnt <= '0;
                    if (hidx == 4'd15) begin
                        active <= 1'b0;
                        sck    <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        hidx <= hidx + 1'b1;
                        sck  <= ~hidx[0];
                        if (hidx[0]) sh <= {sh[6:0], 1'b0};
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            tmr_fin,
    input  logic            spi_fin,
    output logic            tmr_load,
    output logic [MS_W-1:0] tmr_ms,
    output logic            spi_go,
    output logic [7:0]      spi_byte,
    output logic            cs_n,
    output logic            dc,
    output logic            panel_rst_n,
    output logic            busy,
    output logic            done
);
    seq_state_e      state;
    logic [PC_W-1:0] pc;
    seq_step_t       cur;

    always_comb begin
        cur      = step_at(pc);
        tmr_load = (state == ST_STEP) && (cur.op == OP_PANRST || cur.op == OP_PAUSE);
        tmr_ms   = cur.val;
        spi_go   = (state == ST_STEP) && (cur.op == OP_SEND);
        spi_byte = cur.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_STEP;
            pc          <= '0;
            cs_n        <= 1'b1;
            dc          <= 1'b0;
            panel_rst_n <= 1'b1;
            busy        <= 1'b1;
            done        <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_STEP;
                        pc    <= '0;
                        busy  <= 1'b1;
                        done  <= 1'b0;
                    end
                end
                ST_STEP: begin
                    case (cur.op)
                        OP_CSN: begin
                            cs_n <= cur.val[0];
                            pc   <= pc + 1'b1;
                        end
                        OP_DCSEL: begin
                            dc <= cur.val[0];
                            pc <= pc + 1'b1;
                        end
                        OP_PANRST: begin
                            panel_rst_n <= 1'b0;
                            state       <= ST_TMR;
                        end
                        OP_PAUSE: state <= ST_TMR;
                        OP_SEND:  state <= ST_SPI;
                        default: begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    endcase
                end
                ST_SPI: begin
                    if (spi_fin) begin
                        pc    <= pc + 1'b1;
                        state <= ST_STEP;
                    end
                end
                ST_TMR: begin
                    if (tmr_fin) begin
                        panel_rst_n <= 1'b1;
                        pc          <= pc + 1'b1;
                        state       <= ST_STEP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SCK_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic lcd_cs_n,
    output logic lcd_dc,
    output logic lcd_rst_n,
    output logic lcd_sck,
    output logic lcd_mosi,
    output logic busy,
    output logic done
);
    localparam int    TICK_CYC   = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;
    localparam longint SCK_MIN   = (longint'(CLK_HZ) * 3 + 64'd9_999_999) / 64'd10_000_000;
    localparam int    HALF_FLOOR = int'((SCK_MIN + 1) / 2);
    localparam int    HALF_USE   = (SCK_HALF > HALF_FLOOR) ? SCK_HALF : HALF_FLOOR;

    logic            tmr_load, tmr_fin, spi_go, spi_fin;
    logic [MS_W-1:0] tmr_ms;
    logic [7:0]      spi_byte;

    lcd_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tmr_fin    (tmr_fin),
        .spi_fin    (spi_fin),
        .tmr_load   (tmr_load),
        .tmr_ms     (tmr_ms),
        .spi_go     (spi_go),
        .spi_byte   (spi_byte),
        .cs_n       (lcd_cs_n),
        .dc         (lcd_dc),
        .panel_rst_n(lcd_rst_n),
        .busy       (busy),
        .done       (done)
    );

    lcd_ms_timer #(.TICK_CYC(TICK_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .load_ms(tmr_ms),
        .fin    (tmr_fin)
    );

    lcd_spi_byte_tx #(.HALF(HALF_USE)) u_spi (
        .clk (clk),
        .rst (rst),
        .go  (spi_go),
        .din (spi_byte),
        .sck (lcd_sck),
        .mosi(lcd_mosi),
        .fin (spi_fin)
    );
endmodule

// File: rtl/lcd_bringup_seq_chk.sv
module lcd_bringup_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cs_n,
    input logic dc,
    input logic rst_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic done
);
    assert_cs_dc_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !rst_n |-> (!cs_n && !dc));

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    assert_dc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(dc));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_rerun_R9: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (busy && !done));

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind lcd_bringup_seq lcd_bringup_seq_chk i_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .cs_n (lcd_cs_n),
    .dc   (lcd_dc),
    .rst_n(lcd_rst_n),
    .sck  (lcd_sck),
    .mosi (lcd_mosi),
    .busy (busy),
    .done (done)
);

// File: tb/test_lcd_bringup_seq.sv
module test_lcd_bringup_seq;
    localparam int T_CLK_HZ = 20_000;
    localparam int TICK     = T_CLK_HZ / 1000;
    localparam int HALF     = 2;
    localparam int NBYTES   = 11;
    localparam int SLACK    = 40;

    // {expected byte, minimum ms gap before it; FF = not checked}
    localparam logic [15:0] VEC [NBYTES] = '{
        16'hA3FF, 16'hA000, 16'hC800, 16'hC200, 16'h4000, 16'h2C00,
        16'h2E32, 16'h2F32, 16'h260A, 16'hAF00, 16'hA600
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic lcd_cs_n, lcd_dc, lcd_rst_n, lcd_sck, lcd_mosi, busy, done;

    always #4 clk = ~clk;

    lcd_bringup_seq #(.CLK_HZ(T_CLK_HZ), .SCK_HALF(HALF)) i_lcd_bringup_seq (
        .clk(clk), .rst(rst), .start(start),
        .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_rst_n(lcd_rst_n),
        .lcd_sck(lcd_sck), .lcd_mosi(lcd_mosi), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_err = 0;

    int cyc = 0;
    int n_rx = 0;
    int bitn = 0;
    logic [7:0] shv = '0;
    logic [7:0] rx_b [64];
    logic       rx_dc [64];
    int rx_first [64];
    int rx_last  [64];
    int prev_rise = 0;
    int per_min = 1 << 30;
    int per_max = 0;
    int sck_idle_bad = 0;
    int n_rst = 0;
    int rst_fall [8];
    int rst_rise [8];
    logic rst_cs [8];
    logic rst_dc [8];
    int rst_nb_fall [8];
    int rst_nb_rise [8];
    int cs_rise = 0;
    int done_rise = 0;
    logic p_sck = 1'b0, p_rst_n = 1'b1, p_cs_n = 1'b1, p_done = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            bitn = 0;
        end else begin
            if (lcd_sck && !p_sck && !lcd_cs_n) begin
                if (bitn == 0) begin
                    if (n_rx < 64) rx_first[n_rx] = cyc;
                end else begin
                    if (cyc - prev_rise < per_min) per_min = cyc - prev_rise;
                    if (cyc - prev_rise > per_max) per_max = cyc - prev_rise;
                end
                prev_rise = cyc;
                shv = {shv[6:0], lcd_mosi};
                bitn++;
                if (bitn == 8) begin
                    if (n_rx < 64) begin
                        rx_b[n_rx]    = shv;
                        rx_dc[n_rx]   = lcd_dc;
                        rx_last[n_rx] = cyc;
                    end
                    n_rx++;
                    bitn = 0;
                end
            end
            if (lcd_cs_n && lcd_sck) sck_idle_bad++;
            if (!lcd_rst_n && p_rst_n && n_rst < 8) begin
                rst_fall[n_rst]    = cyc;
                rst_cs[n_rst]      = lcd_cs_n;
                rst_dc[n_rst]      = lcd_dc;
                rst_nb_fall[n_rst] = n_rx;
            end
            if (lcd_rst_n && !p_rst_n && n_rst < 8) begin
                rst_rise[n_rst]    = cyc;
                rst_nb_rise[n_rst] = n_rx;
                n_rst++;
            end
            if (lcd_cs_n && !p_cs_n) cs_rise = cyc;
            if (done && !p_done) done_rise = cyc;
        end
        p_sck   = lcd_sck;
        p_rst_n = lcd_rst_n;
        p_cs_n  = lcd_cs_n;
        p_done  = done;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", n, limit);
        end
    endtask

    task automatic reset_state_check(input string tag);
        chk(lcd_cs_n == 1'b1, "R1", {tag, " cs_n"}, lcd_cs_n, 1);
        chk(lcd_dc == 1'b0, "R1", {tag, " dc"}, lcd_dc, 0);
        chk(lcd_rst_n == 1'b1, "R1", {tag, " rst_n"}, lcd_rst_n, 1);
        chk(lcd_sck == 1'b0, "R1", {tag, " sck"}, lcd_sck, 0);
        chk(done == 1'b0, "R1", {tag, " done"}, done, 0);
        chk(busy == 1'b1, "R1", {tag, " busy"}, busy, 1);
    endtask

    task automatic verify_run(input int base, input int ri);
        int d;
        int g;
        chk(n_rst == ri + 1, "R3", "reset pulses so far", n_rst, ri + 1);
        chk(rst_cs[ri] == 1'b0, "R2", "cs_n at reset fall", rst_cs[ri], 0);
        chk(rst_dc[ri] == 1'b0, "R2", "dc at reset fall", rst_dc[ri], 0);
        chk(rst_nb_fall[ri] == base, "R2", "bytes before reset", rst_nb_fall[ri], base);
        d = rst_rise[ri] - rst_fall[ri];
        chk(d >= 242 * TICK && d <= 242 * TICK + 4, "R3", "reset low cycles", d, 242 * TICK);
        chk(rst_nb_rise[ri] == base, "R3", "bytes during reset", rst_nb_rise[ri], base);
        chk(n_rx == base + NBYTES, "R8", "bytes in run", n_rx - base, NBYTES);
        for (int k = 0; k < NBYTES; k++) begin
            chk(rx_b[base + k] == VEC[k][15:8], "R4", $sformatf("byte %0d", k),
                rx_b[base + k], VEC[k][15:8]);
            chk(rx_dc[base + k] == 1'b0, "R4", $sformatf("dc of byte %0d", k),
                rx_dc[base + k], 0);
            if (k > 0 && VEC[k][7:0] != 8'hFF) begin
                g = rx_first[base + k] - rx_last[base + k - 1];
                chk(g >= int'(VEC[k][7:0]) * TICK && g <= int'(VEC[k][7:0]) * TICK + SLACK,
                    "R6", $sformatf("gap before byte %0d", k), g, int'(VEC[k][7:0]) * TICK);
            end
        end
        d = cs_rise - rx_last[base + NBYTES - 1];
        chk(d >= 100 * TICK && d <= 100 * TICK + SLACK, "R7", "final wait", d, 100 * TICK);
        d = done_rise - cs_rise;
        chk(d >= 0 && d <= 4, "R7", "done after cs release", d, 1);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_state_check("in reset");
        rst = 1'b0;

        // run 1: auto start, start pulse while busy (R8)
        repeat (2000) @(negedge clk);
        chk(busy == 1'b1, "R1", "auto run busy", busy, 1);
        pulse_start();
        wait_done(20000);
        @(negedge clk);
        verify_run(0, 0);

        // R10 idle after done
        repeat (500) @(negedge clk);
        chk(n_rx == NBYTES, "R10", "no bytes while done", n_rx, NBYTES);
        chk(lcd_cs_n == 1'b1 && lcd_rst_n == 1'b1, "R10", "idle lines", {lcd_cs_n, lcd_rst_n}, 3);
        chk(busy == 1'b0 && done == 1'b1, "R10", "done flags", {busy, done}, 1);

        // run 2: R9 re-run, with start during the byte phase (R8)
        pulse_start();
        chk(busy == 1'b1 && done == 1'b0, "R9", "rerun flags", {busy, done}, 2);
        repeat (4960) @(negedge clk);
        pulse_start();
        wait_done(20000);
        @(negedge clk);
        verify_run(NBYTES, 1);

        // run 3: reset mid-run restarts from top (R1)
        pulse_start();
        repeat (1000) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        reset_state_check("mid-run reset");
        rst = 1'b0;
        wait_done(20000);
        @(negedge clk);
        verify_run(2 * NBYTES, 2);

        // R5 serial timing
        chk(per_min == 2 * HALF && per_max == 2 * HALF, "R5", "sck period",
            per_max, 2 * HALF);
        chk(sck_idle_bad == 0, "R5", "sck high with cs released", sck_idle_bad, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule